// File: doc/BRIEF.md
# Serial Audio Sample Receiver

This block takes the serial data line of an audio converter that runs in short-frame-sync mode and turns one slot per frame into a parallel sample word. Everything runs on a fast system clock. Two strobes pace the bit timing: a single-cycle enable marks each bit-clock falling edge, and a frame marker starts each frame. The receiver reads the line only in cycles where the enable is high.

A frame marker seen on an enabled edge arms the receiver. The next 16 enabled edges shift in one sample, most significant bit first. The finished word then appears on the output together with a one-cycle valid strobe. After that the receiver ignores the line until the next frame marker. A marker that arrives in the middle of a word throws away the partial word and starts again. The surrounding system supplies a bit period of 48 system cycles and a frame of 64 bit periods, so the block delivers one sample per frame.

The controller has three states. In `RX_IDLE` it waits for a marker. In `RX_SHIFT` it collects bits. `RX_DONE` lasts one cycle and presents the finished word. There are three transitions. *arm* goes from any state to `RX_SHIFT` on an enabled edge with the marker high. *last bit* goes from `RX_SHIFT` to `RX_DONE` on the sixteenth data edge. *retire* goes from `RX_DONE` to `RX_IDLE` in the following cycle.

Top module: `audio_slot_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sample_o` is 0 and `sample_valid_o` is 0.
- R2: The line is sampled only in cycles where `bit_tick_i` is 1. Line values in all other cycles have no effect on the delivered word.
- R3: The receiver arms only when `frame_sync_i` is 1 in a cycle where `bit_tick_i` is 1. The line value at that arming edge is not part of the word. The first data bit is taken at the next enabled edge. A marker held high only in cycles without the enable arms nothing.
- R4: Bits arrive most significant first. The k-th data bit after arming (k = 0..15) lands in `sample_o[15-k]`.
- R5: After the sixteenth data bit, `sample_o` shows the new word and `sample_valid_o` is 1. Both take effect in the cycle after the enabled cycle that carried that bit, and `sample_valid_o` stays high for exactly one cycle.
- R6: `sample_o` changes only in a cycle where `sample_valid_o` is 1. Otherwise it holds the last word.
- R7: After a word is complete, further enabled edges without a marker change neither output until the next marker.
- R8: A marker on an enabled edge in the middle of a word discards the bits collected so far. The next word is built from the 16 data bits that follow the new marker.
- R9: With a bit period of 48 system cycles and a frame of 64 bit periods, each frame yields exactly one valid strobe carrying that frame's first slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_tick_i | input | 1 | Single-cycle enable at each bit-clock falling edge |
| frame_sync_i | input | 1 | Frame marker, high for one bit period |
| ser_data_i | input | 1 | Serial data line from the converter |
| sample_o | output | SAMPLE_W (16) | Last completed sample word |
| sample_valid_o | output | 1 | One-cycle strobe when a new word is presented |

## Verification
The assertions assume that all inputs are synchronous to the system clock. They also assume the frame marker matters only in enabled cycles, so any rearm they check is tied to a cycle where the enable and the marker are both high. The bench drives every input at the falling clock edge. It keeps the enable to isolated single cycles with at least three quiet cycles between them, and it drives the inverted data bit in those quiet cycles so that any stray sampling corrupts the word. Markers come either across a full bit slot, as a converter interface sends them, or deliberately only in cycles without the enable, to exercise R3.

// File: rtl/audio_slot_rx_pkg.sv
package audio_slot_rx_pkg;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_SHIFT = 2'd1,
        RX_DONE  = 2'd2
    } rx_state_e;

endpackage

// File: rtl/slot_rx_ctrl.sv
module slot_rx_ctrl
    import audio_slot_rx_pkg::*;
#(
    parameter int SAMPLE_W = 16
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic sync_i,
    output logic shift_en_o,
    output logic word_done_o,
    output logic valid_o
);

    localparam int CNT_W = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SAMPLE_W - 1);

    rx_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             arm;

    // output process
    always_comb begin
        arm         = tick_i && sync_i;
        shift_en_o  = tick_i && !sync_i && (state_q == RX_SHIFT);
        word_done_o = shift_en_o && (cnt_q == '0);
        valid_o     = (state_q == RX_DONE);
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE:  state_d = RX_IDLE;
            RX_SHIFT: if (word_done_o) state_d = RX_DONE;
            RX_DONE:  state_d = RX_IDLE;
            default:  state_d = RX_IDLE;
        endcase
        if (arm) state_d = RX_SHIFT;
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RX_IDLE;
        else         state_q <= state_d;
    end

    // bit counter: counts down from the top bit index
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         cnt_q <= '0;
        else if (arm)        cnt_q <= LAST_IDX;
        else if (shift_en_o) cnt_q <= cnt_q - 1'b1;
    end

    // R5
    valid_one_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |=> !valid_o);

    // R5
    valid_follows_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o |-> $past(tick_i));

    // R7
    idle_stays_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == RX_IDLE && !(tick_i && sync_i)) |=> (state_q == RX_IDLE));

    // R8
    sync_rearms_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && sync_i) |=> (state_q == RX_SHIFT && cnt_q == LAST_IDX));

    // R2
    no_tick_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!tick_i && state_q == RX_SHIFT) |=> (state_q == RX_SHIFT && $stable(cnt_q)));

endmodule

// File: rtl/slot_rx_shift.sv
module slot_rx_shift #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                shift_en_i,
    input  logic                load_i,
    input  logic                din_i,
    output logic [SAMPLE_W-1:0] word_o
);

    logic [SAMPLE_W-1:0] sreg_q;
    logic [SAMPLE_W-1:0] word_q;
    logic [SAMPLE_W-1:0] next_sreg;

    assign next_sreg = {sreg_q[SAMPLE_W-2:0], din_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)         sreg_q <= '0;
        else if (shift_en_i) sreg_q <= next_sreg;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     word_q <= '0;
        else if (load_i) word_q <= next_sreg;
    end

    assign word_o = word_q;

    // R7
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !load_i |=> $stable(word_o));

endmodule

// File: rtl/audio_slot_rx.sv
module audio_slot_rx #(
    parameter int SAMPLE_W = 16
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                bit_tick_i,
    input  logic                frame_sync_i,
    input  logic                ser_data_i,
    output logic [SAMPLE_W-1:0] sample_o,
    output logic                sample_valid_o
);

    logic shift_en;
    logic word_done;

    slot_rx_ctrl #(.SAMPLE_W(SAMPLE_W)) u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tick_i      (bit_tick_i),
        .sync_i      (frame_sync_i),
        .shift_en_o  (shift_en),
        .word_done_o (word_done),
        .valid_o     (sample_valid_o)
    );

    slot_rx_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .shift_en_i (shift_en),
        .load_i     (word_done),
        .din_i      (ser_data_i),
        .word_o     (sample_o)
    );

    // R6
    data_moves_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(sample_o) |-> sample_valid_o);

    // R1
    always @(negedge clk_i) begin
        if (!rst_ni) begin
            reset_outputs_chk: assert (sample_o == '0 && !sample_valid_o);
        end
    end

endmodule

// File: tb/audio_slot_rx_test.sv
module audio_slot_rx_test;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick = 1'b0;
    logic         sync = 1'b0;
    logic         din = 1'b0;
    logic [W-1:0] sample;
    logic         valid;

    always #2 clk = ~clk;

    audio_slot_rx #(.SAMPLE_W(W)) uut (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .bit_tick_i     (tick),
        .frame_sync_i   (sync),
        .ser_data_i     (din),
        .sample_o       (sample),
        .sample_valid_o (valid)
    );

    int    checks = 0;
    int    fails = 0;
    int    valid_seen = 0;
    string cur_req = "R1";

    // behavioural reference model
    int           m_armed;
    int           m_got;
    logic [W-1:0] m_acc;
    logic [W-1:0] m_word;
    logic         m_valid;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_armed = 0; m_got = 0; m_acc = '0; m_word = '0; m_valid = 1'b0;
        end else begin
            m_valid = 1'b0;
            if (tick) begin
                if (sync) begin
                    m_armed = 1; m_got = 0;
                end else if (m_armed != 0) begin
                    m_acc = {m_acc[W-2:0], din};
                    m_got++;
                    if (m_got == W) begin
                        m_word = m_acc; m_valid = 1'b1; m_armed = 0;
                    end
                end
            end
        end
    end

    always @(posedge clk) if (rst_n && valid) valid_seen++;

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        checks++;
        if (sample !== m_word || valid !== m_valid) begin
            fails++;
            $display("FAIL %s: sample=%h valid=%b expected sample=%h valid=%b",
                     cur_req, sample, valid, m_word, m_valid);
        end
    end

    task automatic check(input bit ok, input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic slot(input logic s, input logic d, input int gap);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk); tick = 1'b0; sync = s; din = ~d;
        end
        @(negedge clk); tick = 1'b1; sync = s; din = d;
    endtask

    task automatic send_word(input logic [W-1:0] w, input int gap, input string req);
        slot(1'b1, ~w[W-1], gap);
        for (int i = 0; i < W; i++) slot(1'b0, w[W-1-i], gap);
        @(negedge clk); tick = 1'b0; sync = 1'b0;
        check(valid === 1'b1 && sample === w, req, sample, w);
        @(negedge clk);
        check(valid === 1'b0, "R5", {{(W-1){1'b0}}, valid}, '0);
    endtask

    initial begin
        int vs;
        logic [W-1:0] held;
        // R1: reset with toggling inputs
        for (int i = 0; i < 6; i++) begin
            @(negedge clk); tick = 1'($urandom); sync = 1'($urandom); din = 1'($urandom);
            check(sample === '0 && valid === 1'b0, "R1", sample, '0);
        end
        @(negedge clk); tick = 1'b0; sync = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        check(sample === '0 && valid === 1'b0, "R1", sample, '0);

        cur_req = "R4";
        send_word(16'hA5C3, 3, "R4");
        send_word(16'h8001, 3, "R4");
        cur_req = "R2";
        send_word(16'hFFFF, 3, "R2");
        send_word(16'h0000, 3, "R2");

        // R7: extra slots after a word
        cur_req = "R7";
        send_word(16'h3C5A, 3, "R7");
        vs = valid_seen;
        for (int i = 0; i < 20; i++) slot(1'b0, 1'($urandom), 3);
        @(negedge clk); tick = 1'b0;
        check(valid_seen == vs && sample === 16'h3C5A, "R7", sample, 16'h3C5A);

        // R8: marker in the middle of a word
        cur_req = "R8";
        slot(1'b1, 1'b0, 3);
        for (int i = 0; i < 7; i++) slot(1'b0, 1'b1, 3);
        vs = valid_seen;
        send_word(16'h1234, 3, "R8");
        check(valid_seen == vs + 1, "R8", W'(valid_seen - vs), W'(1));

        // R3: marker only in cycles without the enable
        cur_req = "R3";
        held = sample;
        vs = valid_seen;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); tick = 1'b0; sync = 1'b1; din = 1'b1;
        end
        for (int i = 0; i < W + 2; i++) slot(1'b0, 1'($urandom), 3);
        @(negedge clk); tick = 1'b0;
        check(valid_seen == vs && sample === held, "R3", sample, held);

        // R9: full-rate frames
        cur_req = "R9";
        for (int f = 0; f < 2; f++) begin
            logic [W-1:0] w;
            w = W'($urandom);
            vs = valid_seen;
            send_word(w, 47, "R9");
            for (int i = 0; i < 64 - W - 1; i++) slot(1'b0, 1'($urandom), 47);
            @(negedge clk); tick = 1'b0;
            check(valid_seen == vs + 1 && sample === w, "R9", sample, w);
        end

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule